// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional

This block keeps the atomic-update reservation of one core. The core sends a plain load, a load-linked or a store-conditional to a small word memory inside the block. A load-linked returns the word and opens a reservation on the cache line that holds it. A store-conditional commits its data only if that reservation has survived. It reports success as a single bit, and it always ends the reservation.

Other agents write the same memory through a snoop port with a valid/ready handshake. An accepted snoop write to the reserved line breaks the reservation. Lines are compared with the low offset bits ignored, so a write to a neighbouring word in the line counts as a conflict. A kill input stands for events such as a context switch or a translation miss, and drops the reservation at once.

To guarantee forward progress, each load-linked loads a guard count. While that count is non-zero, a conflicting snoop write is held off with ready low. When the count runs out, the write is accepted and clears the reservation.

Top module: `llsc_monitor`

## Requirements
- R1: During and after reset, rsp_valid is 0, no reservation is held, and every memory word reads 0.
- R2: Each request cycle gives one response cycle later, and only then: rsp_valid is 1 with the word read at the request cycle. Opcodes 2'b00 and 2'b01 are plain loads, with rsp_sc_ok 0, and they leave the reservation unchanged.
- R3: A load-linked (opcode 2'b10) returns the addressed word and sets the reservation on that word's line, where line = address with the low OFFW bits dropped.
- R4: A store-conditional (opcode 2'b11) with the reservation set writes its data to memory and returns rsp_sc_ok = 1.
- R5: A store-conditional with no reservation writes nothing and returns rsp_sc_ok = 0.
- R6: Every store-conditional clears the reservation, whether it succeeds or fails.
- R7: An accepted snoop write updates memory. If it hits the reserved line (any word in it), it clears the reservation.
- R8: An accepted snoop write to any other line leaves the reservation intact.
- R9: After a load-linked with guard value G, a snoop to the reserved line sees snp_ready low for exactly G cycles. It is then accepted and clears the reservation. Snoops to other lines are not held.
- R10: resv_kill clears the reservation and overrides a load-linked or store-conditional in the same cycle, so that store-conditional fails and writes nothing.
- R11: A new load-linked replaces any earlier reservation, so snoops to the old line no longer break it.
- R12: snp_ready is 0 in every cycle where req_valid is 1, since the core takes the memory port first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present this cycle |
| req_op | input | 2 | 00/01 load, 10 load-linked, 11 store-conditional |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store-conditional data |
| guard_cycles | input | GW | Protection window loaded by a load-linked |
| rsp_valid | output | 1 | Response one cycle after the request |
| rsp_rdata | output | DW | Read data (0 for store-conditional) |
| rsp_sc_ok | output | 1 | Store-conditional success |
| snp_valid | input | 1 | Foreign write offered |
| snp_addr | input | AW | Foreign write word address |
| snp_wdata | input | DW | Foreign write data |
| snp_ready | output | 1 | Foreign write accepted this cycle |
| resv_kill | input | 1 | Drop reservation (context switch, translation miss) |

## Verification
The bench builds the block with 16 words of 16 bits, four words per line (OFFW = 2) and a 3-bit guard. This is small enough to sweep every reserved address against every snoop address and every guard value from 0 to 7. Expected memory contents, success bits and stall lengths come from a bench-side memory model and line arithmetic. The sweeps reach same-word, same-line-other-word and other-line conflicts, the zero-length guard, replacement of a reservation, and a kill that coincides with a request.

// File: rtl/llsc_pkg.sv
// Shared types for the reservation monitor.
// Assumes a two-bit request opcode coming from the core.
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD   = 2'b00,
        OP_LOAD_B = 2'b01,
        OP_LINK   = 2'b10,
        OP_COND   = 2'b11
    } llsc_op_e;
endpackage

// File: rtl/llsc_wordmem.sv
// Small word memory: one write port, one asynchronous read port.
// Every word resets to zero. The caller guarantees one writer per cycle.
module llsc_wordmem #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] words [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_word
            // Each word: clear on reset, load on a write to its own index.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    words[g] <= '0;
                else if (we && (waddr == AW'(g)))
                    words[g] <= wdata;
            end
        end
    endgenerate

    // Combinational read of the addressed word.
    assign rdata = words[raddr];
endmodule

// File: rtl/llsc_resv.sv
// Reservation state: lock flag, reserved line and forward-progress counter.
// Event priority, highest first: kill, link, conditional, snoop hit, then
// a countdown of the guard.
module llsc_resv #(
    parameter int LW = 2,
    parameter int GW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kill,
    input  logic          link_set,
    input  logic [LW-1:0] link_line,
    input  logic [GW-1:0] guard_load,
    input  logic          cond_done,
    input  logic          snp_fire,
    input  logic [LW-1:0] snp_line,
    output logic          flag,
    output logic [LW-1:0] line,
    output logic          guard_busy,
    output logic          snp_stall
);
    logic [GW-1:0] guard_cnt;
    logic          snp_hit;

    // A snoop targets the live reservation.
    assign snp_hit    = flag && (snp_line == line);
    assign guard_busy = (guard_cnt != '0);
    // A conflicting snoop is held while the guard runs.
    assign snp_stall  = snp_hit && guard_busy;

    // Update the flag, line and guard counter on each event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag      <= 1'b0;
            line      <= '0;
            guard_cnt <= '0;
        end else if (kill) begin
            flag      <= 1'b0;
            guard_cnt <= '0;
        end else if (link_set) begin
            flag      <= 1'b1;
            line      <= link_line;
            guard_cnt <= guard_load;
        end else if (cond_done || (snp_fire && snp_hit)) begin
            flag      <= 1'b0;
            guard_cnt <= '0;
        end else if (guard_busy) begin
            guard_cnt <= guard_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
// Top of the reservation monitor. The core request has priority over the
// snoop port for the memory, and responses come one cycle after requests.
// A store-conditional checks only the lock flag, not its own address.
module llsc_monitor #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int OFFW  = 2,
    parameter int GW    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW - OFFW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [GW-1:0] guard_cycles,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_sc_ok,
    input  logic          snp_valid,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_wdata,
    output logic          snp_ready,
    input  logic          resv_kill
);
    import llsc_pkg::*;

    llsc_op_e      op;
    logic          is_link, is_cond, cond_ok, snp_fire;
    logic          resv_flag, guard_busy, snp_stall;
    logic [LW-1:0] resv_line;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    // Decode the request.
    assign op      = llsc_op_e'(req_op);
    assign is_link = req_valid && (op == OP_LINK);
    assign is_cond = req_valid && (op == OP_COND);
    assign cond_ok = is_cond && resv_flag && !resv_kill;

    // The snoop is accepted only when the core is idle and the guard allows it.
    assign snp_ready = !req_valid && !snp_stall;
    assign snp_fire  = snp_valid && snp_ready;

    // Choose the single memory writer.
    always_comb begin
        mem_we    = cond_ok || snp_fire;
        mem_waddr = cond_ok ? req_addr  : snp_addr;
        mem_wdata = cond_ok ? req_wdata : snp_wdata;
    end

    llsc_wordmem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (req_addr),
        .rdata (mem_rdata)
    );

    llsc_resv #(.LW(LW), .GW(GW)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .kill       (resv_kill),
        .link_set   (is_link),
        .link_line  (req_addr[AW-1:OFFW]),
        .guard_load (guard_cycles),
        .cond_done  (is_cond),
        .snp_fire   (snp_fire),
        .snp_line   (snp_addr[AW-1:OFFW]),
        .flag       (resv_flag),
        .line       (resv_line),
        .guard_busy (guard_busy),
        .snp_stall  (snp_stall)
    );

    // Register the response of each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_sc_ok <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= is_cond ? '0 : mem_rdata;
            rsp_sc_ok <= cond_ok;
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
// Assertion checker for llsc_monitor, attached with bind below.
module llsc_monitor_chk #(
    parameter int AW = 4,
    parameter int LW = 2,
    parameter int OFFW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_op,
    input logic          rsp_valid,
    input logic          rsp_sc_ok,
    input logic          snp_valid,
    input logic [AW-1:0] snp_addr,
    input logic          snp_ready,
    input logic          resv_kill,
    input logic          resv_flag,
    input logic [LW-1:0] resv_line,
    input logic          guard_busy
);
    logic snp_match;
    assign snp_match = resv_flag && (snp_addr[AW-1:OFFW] == resv_line);

    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_stray_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_sc_fails_unreserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11 && !resv_flag) |=> !rsp_sc_ok);
    p_sc_drops_resv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11) |=> !resv_flag);
    p_snoop_hit_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_ready && snp_match) |=> !resv_flag);
    p_guard_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_match && guard_busy) |-> !snp_ready);
    p_kill_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resv_kill |=> !resv_flag);
    p_core_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !snp_ready);
endmodule

bind llsc_monitor llsc_monitor_chk #(.AW(AW), .LW(LW), .OFFW(OFFW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .rsp_valid  (rsp_valid),
    .rsp_sc_ok  (rsp_sc_ok),
    .snp_valid  (snp_valid),
    .snp_addr   (snp_addr),
    .snp_ready  (snp_ready),
    .resv_kill  (resv_kill),
    .resv_flag  (resv_flag),
    .resv_line  (resv_line),
    .guard_busy (guard_busy)
);

// File: tb/llsc_monitor_bench.sv
// Sweep bench for llsc_monitor with 16 words, 4 words per line, 3-bit guard.
module llsc_monitor_bench;
    localparam int DW = 16, DEPTH = 16, OFFW = 2, GW = 3, AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [GW-1:0] guard_cycles = '0;
    logic          rsp_valid, rsp_sc_ok, snp_ready;
    logic [DW-1:0] rsp_rdata;
    logic          snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_wdata = '0;
    logic          resv_kill = 1'b0;

    int checks = 0, fails = 0;
    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] rd;
    logic          ok;
    int            waited;

    always #10 clk = ~clk;

    llsc_monitor #(.DW(DW), .DEPTH(DEPTH), .OFFW(OFFW), .GW(GW)) u_llsc_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .guard_cycles(guard_cycles),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_wdata(snp_wdata),
        .snp_ready(snp_ready), .resv_kill(resv_kill)
    );

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Enter and leave at a negedge; the response is sampled at the next negedge.
    task automatic req(input logic [1:0] op, input int a, input int d, input int g,
                       input bit kill, output logic [DW-1:0] r, output logic s);
        req_valid = 1'b1; req_op = op; req_addr = AW'(a);
        req_wdata = DW'(d); guard_cycles = GW'(g); resv_kill = kill;
        @(negedge clk);
        req_valid = 1'b0; resv_kill = 1'b0;
        check(rsp_valid == 1'b1, "R2 rsp_valid", int'(rsp_valid), 1);
        r = rsp_rdata; s = rsp_sc_ok;
    endtask

    task automatic snoop(input int a, input int d, output int w);
        snp_valid = 1'b1; snp_addr = AW'(a); snp_wdata = DW'(d); w = 0;
        #1;
        while (!snp_ready && w < 50) begin
            w++;
            @(negedge clk); #1;
        end
        @(negedge clk);
        snp_valid = 1'b0;
        model[a] = DW'(d);
    endtask

    task automatic kill_pulse();
        resv_kill = 1'b1;
        @(negedge clk);
        resv_kill = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1 rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 rsp_valid idle", int'(rsp_valid), 0);
        for (int a = 0; a < DEPTH; a++) begin
            req(2'b00, a, 0, 0, 0, rd, ok);
            check(rd == '0, "R1 reset word", int'(rd), 0);
            model[a] = '0;
        end
        req(2'b11, 3, 16'h1234, 0, 0, rd, ok);
        check(ok == 1'b0, "R1 no reservation after reset", int'(ok), 0);
        req(2'b00, 3, 0, 0, 0, rd, ok);
        check(rd == '0, "R5 failed SC wrote nothing", int'(rd), 0);

        // Fill memory through the snoop port (R7 memory update).
        for (int a = 0; a < DEPTH; a++) begin
            snoop(a, a * 37 + 5, waited);
            check(waited == 0, "R7 unreserved snoop not held", waited, 0);
        end
        for (int a = 0; a < DEPTH; a++) begin
            req(((a % 2) == 0) ? 2'b00 : 2'b01, a, 0, 0, 0, rd, ok);
            check(rd == model[a], "R2 load data", int'(rd), int'(model[a]));
            check(ok == 1'b0, "R2 load sc_ok low", int'(ok), 0);
        end

        // R3 / R4 / R6 on every address.
        for (int a = 0; a < DEPTH; a++) begin
            req(2'b10, a, 0, 0, 0, rd, ok);
            check(rd == model[a], "R3 link data", int'(rd), int'(model[a]));
            req(2'b11, a, a * 11 + 300, 0, 0, rd, ok);
            check(ok == 1'b1, "R4 SC success", int'(ok), 1);
            model[a] = DW'(a * 11 + 300);
            req(2'b11, a, 999, 0, 0, rd, ok);
            check(ok == 1'b0, "R6 second SC fails", int'(ok), 0);
            req(2'b00, a, 0, 0, 0, rd, ok);
            check(rd == model[a], "R5 memory after SC pair", int'(rd), int'(model[a]));
        end

        // R7 / R8 sweep: every reserved address against every snoop address.
        for (int ra = 0; ra < DEPTH; ra++) begin
            for (int sa = 0; sa < DEPTH; sa++) begin
                bit same;
                same = ((ra >> OFFW) == (sa >> OFFW));
                req(2'b10, ra, 0, 0, 0, rd, ok);
                snoop(sa, ra * 16 + sa + 1000, waited);
                req(2'b11, ra, ra * 16 + sa + 5000, 0, 0, rd, ok);
                if (same)
                    check(ok == 1'b0, "R7 same-line snoop breaks reservation", int'(ok), 0);
                else
                    check(ok == 1'b1, "R8 other-line snoop keeps reservation", int'(ok), 1);
                if (!same) model[ra] = DW'(ra * 16 + sa + 5000);
                req(2'b00, ra, 0, 0, 0, rd, ok);
                check(rd == model[ra], "R7 memory after snoop and SC", int'(rd), int'(model[ra]));
            end
        end

        // R9 guard sweep.
        for (int g = 0; g < 8; g++) begin
            req(2'b10, 8, 0, g, 0, rd, ok);
            snoop(9, g + 2000, waited);
            check(waited == g, "R9 stall length", waited, g);
            req(2'b11, 8, 77, 0, 0, rd, ok);
            check(ok == 1'b0, "R9 guarded snoop still clears", int'(ok), 0);
        end
        req(2'b10, 8, 0, 7, 0, rd, ok);
        snoop(0, 2100, waited);
        check(waited == 0, "R9 other line not held", waited, 0);
        req(2'b11, 8, 2200, 0, 0, rd, ok);
        check(ok == 1'b1, "R9 other-line snoop during guard", int'(ok), 1);
        model[8] = DW'(2200);

        // R10 kill cases.
        req(2'b10, 4, 0, 0, 0, rd, ok);
        kill_pulse();
        req(2'b11, 4, 3000, 0, 0, rd, ok);
        check(ok == 1'b0, "R10 kill drops reservation", int'(ok), 0);
        req(2'b10, 4, 0, 0, 1, rd, ok);
        req(2'b11, 4, 3001, 0, 0, rd, ok);
        check(ok == 1'b0, "R10 kill beats same-cycle LL", int'(ok), 0);
        req(2'b10, 4, 0, 0, 0, rd, ok);
        req(2'b11, 4, 3002, 0, 1, rd, ok);
        check(ok == 1'b0, "R10 kill beats same-cycle SC", int'(ok), 0);
        req(2'b00, 4, 0, 0, 0, rd, ok);
        check(rd == model[4], "R10 killed SC wrote nothing", int'(rd), int'(model[4]));

        // R11 replacement.
        req(2'b10, 1, 0, 0, 0, rd, ok);
        req(2'b10, 13, 0, 0, 0, rd, ok);
        snoop(2, 4000, waited);
        req(2'b11, 13, 4001, 0, 0, rd, ok);
        check(ok == 1'b1, "R11 old line no longer reserved", int'(ok), 1);
        model[13] = DW'(4001);
        req(2'b10, 1, 0, 0, 0, rd, ok);
        req(2'b10, 13, 0, 0, 0, rd, ok);
        snoop(14, 4002, waited);
        req(2'b11, 13, 4003, 0, 0, rd, ok);
        check(ok == 1'b0, "R11 new line reserved", int'(ok), 0);

        // R2: plain loads between LL and SC leave the reservation alone.
        req(2'b10, 6, 0, 0, 0, rd, ok);
        req(2'b00, 11, 0, 0, 0, rd, ok);
        req(2'b01, 6, 0, 0, 0, rd, ok);
        req(2'b11, 6, 4100, 0, 0, rd, ok);
        check(ok == 1'b1, "R2 loads keep reservation", int'(ok), 1);

        // R12: core request blocks the snoop port.
        req_valid = 1'b1; req_op = 2'b00; req_addr = '0;
        snp_valid = 1'b1; snp_addr = 4'd15; snp_wdata = 16'h5555;
        #1;
        check(snp_ready == 1'b0, "R12 ready low under request", int'(snp_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(snp_ready == 1'b1, "R12 ready back when idle", int'(snp_ready), 1);
        @(negedge clk);
        snp_valid = 1'b0;
        model[15] = 16'h5555;
        req(2'b00, 15, 0, 0, 0, rd, ok);
        check(rd == model[15], "R7 snoop after block", int'(rd), int'(model[15]));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule